// File: doc/BRIEF.md
# RDS Demodulator Configuration and Status Register Block

This block sits between a CPU read/write bus and the back end of an RDS demodulator. Software configures the back end through one byte-wide control register. That register holds four things: a flag that freezes PLL regulation, so the present phase is kept while the signal is weak; two-bit time-constant codes for the bit-rate PLL and the subcarrier PLL; a bit that turns off quality-driven input selection for the first differential decoder; and two source-select bits.

The block receives four signals from the demodulator: the two extracted data bits, the quality-detector bit and the recovered RDS bit clock. It first passes each of them through a two-flop synchronizer. It then forms a second quality signal as the XOR of the two data bits. From these it drives the chosen data bit and the chosen quality bit to the group decoder that follows.

A status register returns all of these live signals to software. Its top bit is a command bit that only takes writes. Writing a one to it produces a single-cycle reset pulse for the demodulator. The bus read path is combinational on the address.

Top module: `rds_demod_regs`

## Requirements
- R1: While `rst_n` is low and after it is released, the control register reads 0x00, every configuration output is 0, `demod_rst` is 0 and the synchronized inputs are 0.
- R2: A write to address 0x5C loads the control register, which reads back unchanged there. Its fields drive the configuration outputs: bit 7 drives `pll_hold`, bits 6:5 drive `slow_tc` (00=160 ms, 01=80 ms, 10=40 ms, 11=20 ms), bits 4:3 drive `fast_tc` (00=16 ms, 01=8 ms, 10=4 ms, 11=2 ms), bit 2 drives `qsel_off`, bit 1 drives `dsel`, and bit 0 drives `qsrc`.
- R3: `qal_xor` equals the XOR of the synchronized first and second data bits.
- R4: `dat_out` carries the synchronized first data bit when `dsel` is 0 and the synchronized second data bit when `dsel` is 1.
- R5: `qal_out` carries the synchronized detector quality bit when `qsrc` is 0 and `qal_xor` when `qsrc` is 1.
- R6: A read of address 0x5D returns, from bit 7 down to bit 0: 0, `qal_out`, synchronized detector quality, `qal_xor`, `dat_out`, synchronized first data bit, synchronized second data bit, synchronized RDS clock.
- R7: A write to 0x5D with bit 7 set raises `demod_rst` for exactly the one cycle that follows the write. A write to 0x5D with bit 7 clear produces no pulse.
- R8: Writes to 0x5D do not change bits 6:0 of the status register or the control register. Reads of any address other than 0x5C or 0x5D return 0. Writes to any such address change nothing.
- R9: A change on `dat1_in`, `dat2_in`, `qal1_in` or `rdsclk_in` reaches the outputs and the status read two rising clock edges later and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| dat1_in | input | 1 | Data bit from the first differential decoder |
| dat2_in | input | 1 | Data bit from the second differential decoder |
| qal1_in | input | 1 | Quality detector output |
| rdsclk_in | input | 1 | Recovered 1187.5 Hz RDS clock |
| pll_hold | output | 1 | Freeze PLL regulation |
| slow_tc | output | 2 | Time-constant code of the 1187.5 Hz PLL |
| fast_tc | output | 2 | Time-constant code of the 57 kHz PLL |
| qsel_off | output | 1 | Turns off quality-driven input selection for decoder 1 |
| dsel | output | 1 | Data source select |
| qsrc | output | 1 | Quality source select |
| dat_out | output | 1 | Selected data bit |
| qal_out | output | 1 | Selected quality bit |
| qal_xor | output | 1 | XOR of the two synchronized data bits |
| demod_rst | output | 1 | One-cycle demodulator reset pulse |

## Verification
A control write takes effect at the rising edge that samples it. The configuration outputs, the readback and the selection muxes therefore show the new value at the falling edge that follows. The reset pulse is high during the one cycle after the sampling edge and is low again one cycle later. Input changes need two rising edges before they reach the outputs. So the bench drives every input at a falling edge and waits exactly two rising edges before it compares. The latency test also samples after the first of those two edges, to confirm that the old value is still present. Reads are combinational, so the bench sets the address and compares a moment later, still within the low phase of the clock.

// File: rtl/rds_demod_regs.sv
module rds_demod_regs #(
  parameter int          ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h5C,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h5D,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              dat1_in,
  input  logic              dat2_in,
  input  logic              qal1_in,
  input  logic              rdsclk_in,
  output logic              pll_hold,
  output logic [1:0]        slow_tc,
  output logic [1:0]        fast_tc,
  output logic              qsel_off,
  output logic              dsel,
  output logic              qsrc,
  output logic              dat_out,
  output logic              qal_out,
  output logic              qal_xor,
  output logic              demod_rst
);

  localparam int NSIG = 4;

  logic [7:0]      ctrl_q;
  logic [NSIG-1:0] sync_q [SYNC_STAGES];
  logic [NSIG-1:0] live;
  logic            dat1_s, dat2_s, qal1_s, clk_s;
  logic            ctrl_we, stat_we;

  assign ctrl_we = bus_wr && (bus_addr == CTRL_ADDR);
  assign stat_we = bus_wr && (bus_addr == STAT_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) demod_rst <= 1'b0;
    else        demod_rst <= stat_we && bus_wdata[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {dat1_in, dat2_in, qal1_in, rdsclk_in};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end

  assign live = sync_q[SYNC_STAGES-1];
  assign {dat1_s, dat2_s, qal1_s, clk_s} = live;

  assign pll_hold = ctrl_q[7];
  assign slow_tc  = ctrl_q[6:5];
  assign fast_tc  = ctrl_q[4:3];
  assign qsel_off = ctrl_q[2];
  assign dsel     = ctrl_q[1];
  assign qsrc     = ctrl_q[0];

  assign qal_xor = dat1_s ^ dat2_s;
  assign dat_out = dsel ? dat2_s : dat1_s;
  assign qal_out = qsrc ? qal_xor : qal1_s;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_ADDR)
      bus_rdata = ctrl_q;
    else if (bus_addr == STAT_ADDR)
      bus_rdata = {1'b0, qal_out, qal1_s, qal_xor, dat_out, dat1_s, dat2_s, clk_s};
  end

  logic [1:0] ast_age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              ast_age <= '0;
    else if (ast_age != 2'd3) ast_age <= ast_age + 2'd1;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q)); // R2

  AST_XOR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STAT_ADDR) |-> (bus_rdata[4] == (bus_rdata[2] ^ bus_rdata[1]))); // R3

  AST_STAT_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STAT_ADDR) |-> !bus_rdata[7]); // R6

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ast_age != 2'd0 && demod_rst) |-> $past(stat_we && bus_wdata[7])); // R7

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (demod_rst && !(stat_we && bus_wdata[7])) |=> !demod_rst); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != CTRL_ADDR && bus_addr != STAT_ADDR) |-> (bus_rdata == 8'h00)); // R8

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (ast_age == 2'd3) |-> (live == $past({dat1_in, dat2_in, qal1_in, rdsclk_in}, 2))); // R9
    end
  endgenerate

endmodule

// File: tb/sim_rds_demod_regs.sv
module sim_rds_demod_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_wr;
  logic       dat1_in, dat2_in, qal1_in, rdsclk_in;
  logic       pll_hold, qsel_off, dsel, qsrc, dat_out, qal_out, qal_xor, demod_rst;
  logic [1:0] slow_tc, fast_tc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  rds_demod_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dat1_in(dat1_in), .dat2_in(dat2_in), .qal1_in(qal1_in), .rdsclk_in(rdsclk_in),
    .pll_hold(pll_hold), .slow_tc(slow_tc), .fast_tc(fast_tc), .qsel_off(qsel_off),
    .dsel(dsel), .qsrc(qsrc), .dat_out(dat_out), .qal_out(qal_out),
    .qal_xor(qal_xor), .demod_rst(demod_rst)
  );

  // {ctrl[7:0], dat1, dat2, qal1, rdsclk, exp dat_out, exp qal_out, exp status[7:0]}
  localparam logic [21:0] VEC [8] = '{
    {8'h00, 4'b1001, 2'b10, 8'h1D},
    {8'h02, 4'b1010, 2'b01, 8'h74},
    {8'h01, 4'b1111, 2'b10, 8'h2F},
    {8'h03, 4'b0100, 2'b11, 8'h5A},
    {8'hFC, 4'b0011, 2'b01, 8'h61},
    {8'hA9, 4'b0110, 2'b01, 8'h72},
    {8'h56, 4'b1100, 2'b10, 8'h0E},
    {8'h03, 4'b0000, 2'b00, 8'h00}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(string req, logic [7:0] a, logic [7:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00; bus_wr = 1'b0;
    {dat1_in, dat2_in, qal1_in, rdsclk_in} = 4'b1111;
    repeat (3) @(negedge clk);
    check("R1", {pll_hold, slow_tc, fast_tc, qsel_off, dsel, qsrc}, 8'h00);
    check("R1", {7'd0, demod_rst}, 8'h00);
    {dat1_in, dat2_in, qal1_in, rdsclk_in} = 4'b0000;
    rst_n = 1'b1;
    step();
    read_chk("R1", 8'h5C, 8'h00);
    read_chk("R1", 8'h5D, 8'h00);

    foreach (VEC[i]) begin
      logic [21:0] v;
      v = VEC[i];
      {dat1_in, dat2_in, qal1_in, rdsclk_in} = v[13:10];
      bus_write(8'h5C, v[21:14]);
      step();
      check("R2", {pll_hold, slow_tc, fast_tc, qsel_off, dsel, qsrc}, v[21:14]);
      read_chk("R2", 8'h5C, v[21:14]);
      check("R4", {7'd0, dat_out}, {7'd0, v[9]});
      check("R5", {7'd0, qal_out}, {7'd0, v[8]});
      check("R3", {7'd0, qal_xor}, {7'd0, v[4]});
      read_chk("R6", 8'h5D, v[7:0]);
    end

    // R9: latency of two edges
    bus_write(8'h5C, 8'h00);
    step();
    dat1_in = 1'b1;
    step();
    check("R9", {7'd0, dat_out}, 8'h00);
    step();
    check("R9", {7'd0, dat_out}, 8'h01);
    read_chk("R9", 8'h5D, 8'h1C);

    // R7: pulse on write of one, none on write of zero
    bus_write(8'h5D, 8'h80);
    check("R7", {7'd0, demod_rst}, 8'h01);
    step();
    check("R7", {7'd0, demod_rst}, 8'h00);
    read_chk("R7", 8'h5D, 8'h1C);
    bus_write(8'h5D, 8'h00);
    check("R7", {7'd0, demod_rst}, 8'h00);
    step();
    check("R7", {7'd0, demod_rst}, 8'h00);

    // R8: status low bits and ctrl untouched by status writes; unmapped space
    bus_write(8'h5C, 8'h5A);
    bus_write(8'h5D, 8'h7F);
    check("R8", {7'd0, demod_rst}, 8'h00);
    read_chk("R8", 8'h5C, 8'h5A);
    // ctrl 5A: dsel=1 -> dat_out=dat2=0; qsrc=0 -> qal_out=qal1=0; qal_xor=1
    read_chk("R8", 8'h5D, 8'h14);
    bus_write(8'h5E, 8'hFF);
    bus_write(8'h00, 8'h81);
    check("R8", {7'd0, demod_rst}, 8'h00);
    read_chk("R8", 8'h5C, 8'h5A);
    read_chk("R8", 8'h5E, 8'h00);
    read_chk("R8", 8'hFF, 8'h00);
    read_chk("R8", 8'h00, 8'h00);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    #1;
    read_chk("R1", 8'h5C, 8'h00);
    check("R1", {7'd0, dat_out}, 8'h00);
    step();
    rst_n = 1'b1;
    step();

    finish_run();
  end
endmodule